// File: doc/BRIEF.md
# Current-Sector Gated Odd/Even Family Arbiter

This block sits between the load-current sign detectors and the PWM vector sequencer of a two-level, three-phase inverter. Once per PWM period it samples the polarity of the three phase currents and maps them onto one of six current sectors. Within a sector no phase current changes sign. From the sector it decides which of two reduced-common-mode synthesis families may run in the coming period. One family uses only the single-high states (001, 010, 100). The other uses only the double-high states (011, 101, 110). The segment selector asks for a family, and the block answers whether that request is permitted.

The block also predicts the state the bridge actually presents while both switches of a leg are off during a dead-time interval. A leg whose command does not change keeps its level. A leg whose command changes is pulled by its freewheeling current. It sits at the low rail when that current is positive and at the high rail when it is negative. A hazard flag rises when the predicted state is a zero vector (full-rail common-mode excursion) or has the opposite common-mode polarity to the states on either side of the transition. The sequencer can then reject that commutation.

Top module: `cur_sector_family_arbiter`

## Requirements
- R1: While reset is held and after its release, `sector` is 0, `sign_err` is 0 and `fam_ok` is 0 for either family request, until the first valid strobe.
- R2: On a clock edge with `period_stb` high, the sign bits `phase_pos` (bit 2 = phase a, bit 1 = b, bit 0 = c; 1 = positive current) set `sector` in the next cycle as 100→1, 110→2, 010→3, 011→4, 001→5, 101→6.
- R3: Changes of `phase_pos` on edges without `period_stb` change neither `sector` nor `dt_state`.
- R4: A strobe sampling 000 or 111 leaves `sector` unchanged and sets `sign_err`. The next strobe with a valid pattern clears `sign_err`.
- R5: `fam_sel` 0 requests the single-high family and 1 the double-high family. `fam_ok` is 1 only for the single-high family in sectors 2, 4 and 6, and only for the double-high family in sectors 1, 3 and 5. It is 0 while `sector` is 0.
- R6: `dt_state` (bit 2 = a) equals `src_state` in every leg where `src_state` and `dst_state` agree. In a leg that changes, it is 0 if the latched sign is positive and 1 if it is negative.
- R7: Swapping `src_state` and `dst_state` gives the same `dt_state` and `dt_hazard`.
- R8: `dt_hazard` is 1 whenever `dt_state` is 000 or 111.
- R9: Otherwise, `dt_hazard` is 1 exactly when the common-mode polarity of `dt_state` differs from that of `src_state` or of `dst_state`. Polarity is positive for two or more ones and negative otherwise.
- R10: `dt_state` and `dt_hazard` use the signs latched by the last strobe, including an invalid one. They respond combinationally to `src_state` and `dst_state`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_stb | input | 1 | One-cycle PWM period boundary strobe |
| phase_pos | input | 3 | Current sign bits, a/b/c, 1 = positive |
| src_state | input | 3 | Switching state before the transition |
| dst_state | input | 3 | Switching state after the transition |
| fam_sel | input | 1 | Requested family: 0 single-high, 1 double-high |
| sector | output | 3 | Current sector 1..6, 0 before first valid sample |
| fam_ok | output | 1 | Requested family is permitted |
| dt_state | output | 3 | Predicted state during dead time |
| dt_hazard | output | 1 | Dead-time state is zero vector or flips polarity |
| sign_err | output | 1 | Last strobe sampled an impossible sign pattern |

## Verification
A corrupted sector register shows up one cycle after the strobe. It appears both on `sector` and as an inverted `fam_ok` for one of the two family requests, so each strobe followed by two family queries exposes it at once. A wrong latched sign shows up on `dt_state` as soon as a transition that toggles that leg is presented. It can hide behind transitions that leave the leg unchanged, so the vectors toggle every leg in turn. A stuck error flag or a sector that moves without a strobe becomes visible in the cycle after the offending edge.

// File: rtl/csfa_pkg.sv
package csfa_pkg;

   localparam int unsigned NUM_PH     = 3;
   localparam int unsigned NUM_SECTOR = 6;
   localparam int unsigned SECT_W     = $clog2(NUM_SECTOR + 1);

   typedef logic [NUM_PH-1:0] leg_vec_t;
   typedef logic [SECT_W-1:0] sector_t;

   typedef enum logic {
      FAM_SINGLE_HIGH = 1'b0,
      FAM_DOUBLE_HIGH = 1'b1
   } family_e;

   // map a valid sign pattern (a,b,c; 1 = positive) onto its sector
   function automatic sector_t sign_to_sector(input leg_vec_t s);
      sector_t r;
      unique case (s)
         3'b100:  r = sector_t'(1);
         3'b110:  r = sector_t'(2);
         3'b010:  r = sector_t'(3);
         3'b011:  r = sector_t'(4);
         3'b001:  r = sector_t'(5);
         3'b101:  r = sector_t'(6);
         default: r = sector_t'(0);
      endcase
      return r;
   endfunction

   // common-mode polarity: positive when two or more legs are high
   function automatic logic cm_positive(input leg_vec_t v);
      return ((32'(v[2]) + 32'(v[1]) + 32'(v[0])) >= 32'd2);
   endfunction

endpackage

// File: rtl/csfa_sector_track.sv
module csfa_sector_track
   import csfa_pkg::*;
#(
   parameter bit POS_LEVEL = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     stb,
   input  leg_vec_t raw_sign,
   output leg_vec_t lat_pos,
   output sector_t  sector,
   output logic     err
);

   leg_vec_t pos_now;
   logic     pat_valid;
   sector_t  sector_nxt;

   generate
      if (POS_LEVEL) begin : g_pos_high
         assign pos_now = raw_sign;
      end else begin : g_pos_low
         assign pos_now = ~raw_sign;
      end
   endgenerate

   always_comb begin
      pat_valid  = (pos_now != '0) && (pos_now != '1);
      sector_nxt = pat_valid ? sign_to_sector(pos_now) : sector;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_pos <= '0;
         sector  <= '0;
         err     <= 1'b0;
      end else if (stb) begin
         lat_pos <= pos_now;
         sector  <= sector_nxt;
         err     <= ~pat_valid;
      end
   end

   // R3
   hold_no_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stb |=> $stable(sector) && $stable(lat_pos));

   // R4
   bad_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && ((raw_sign == '0) || (raw_sign == '1))) |=> ($stable(sector) && err));

   // R2
   sector_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sector <= sector_t'(NUM_SECTOR));

   // R2
   good_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && (raw_sign != '0) && (raw_sign != '1)) |=> ((sector != '0) && !err));

endmodule

// File: rtl/csfa_family_gate.sv
module csfa_family_gate
   import csfa_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  sector_t sector,
   input  logic    fam_sel,
   output logic    fam_ok
);

   logic single_ok;
   logic double_ok;

   always_comb begin
      // even-numbered sectors admit the single-high family, odd ones the double-high
      single_ok = (sector != '0) && !sector[0];
      double_ok = (sector != '0) &&  sector[0];
      fam_ok    = (family_e'(fam_sel) == FAM_SINGLE_HIGH) ? single_ok : double_ok;
   end

   // R5
   no_grant_unknown_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sector == '0) |-> !fam_ok);

   // R5
   exclusive_family_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(single_ok && double_ok));

endmodule

// File: rtl/csfa_deadtime_pred.sv
module csfa_deadtime_pred
   import csfa_pkg::*;
#(
   parameter bit REG_OUT = 1'b0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  leg_vec_t lat_pos,
   input  leg_vec_t src,
   input  leg_vec_t dst,
   output leg_vec_t dt_state,
   output logic     dt_hazard
);

   leg_vec_t dt_c;
   logic     hz_c;
   logic     zero_vec;
   logic     pol_flip;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_PH; gi++) begin : g_leg
         // a switching leg freewheels against its current direction
         assign dt_c[gi] = (src[gi] ^ dst[gi]) ? ~lat_pos[gi] : src[gi];
      end
   endgenerate

   always_comb begin
      zero_vec = (dt_c == '0) || (dt_c == '1);
      pol_flip = (cm_positive(dt_c) != cm_positive(src)) ||
                 (cm_positive(dt_c) != cm_positive(dst));
      hz_c     = zero_vec || pol_flip;
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dt_state  <= '0;
               dt_hazard <= 1'b0;
            end else begin
               dt_state  <= dt_c;
               dt_hazard <= hz_c;
            end
         end
      end else begin : g_comb
         assign dt_state  = dt_c;
         assign dt_hazard = hz_c;
      end
   endgenerate

   // R6
   steady_leg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((dt_c ^ src) & ~(src ^ dst)) == '0);

   // R8
   zero_vec_hazard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((dt_c == '0) || (dt_c == '1)) |-> hz_c);

   // R9
   same_state_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((src == dst) && (src != '0) && (src != '1)) |-> !hz_c);

endmodule

// File: rtl/cur_sector_family_arbiter.sv
module cur_sector_family_arbiter
   import csfa_pkg::*;
#(
   parameter int unsigned PHASES    = 3,
   parameter bit          POS_LEVEL = 1'b1,
   parameter bit          REG_OUT   = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    period_stb,
   input  logic [PHASES-1:0]       phase_pos,
   input  logic [PHASES-1:0]       src_state,
   input  logic [PHASES-1:0]       dst_state,
   input  logic                    fam_sel,
   output logic [SECT_W-1:0]       sector,
   output logic                    fam_ok,
   output logic [PHASES-1:0]       dt_state,
   output logic                    dt_hazard,
   output logic                    sign_err
);

   generate
      if (PHASES != NUM_PH) begin : g_bad_phases
         $error("cur_sector_family_arbiter: PHASES must equal 3");
      end
   endgenerate

   leg_vec_t lat_pos;
   sector_t  sector_q;

   csfa_sector_track #(.POS_LEVEL(POS_LEVEL)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb      (period_stb),
      .raw_sign (phase_pos),
      .lat_pos  (lat_pos),
      .sector   (sector_q),
      .err      (sign_err)
   );

   csfa_family_gate u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .sector  (sector_q),
      .fam_sel (fam_sel),
      .fam_ok  (fam_ok)
   );

   csfa_deadtime_pred #(.REG_OUT(REG_OUT)) u_dt (
      .clk       (clk),
      .rst_n     (rst_n),
      .lat_pos   (lat_pos),
      .src       (src_state),
      .dst       (dst_state),
      .dt_state  (dt_state),
      .dt_hazard (dt_hazard)
   );

   assign sector = sector_q;

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> (sector == '0) && !sign_err && !fam_ok);

endmodule

// File: tb/sim_cur_sector_family_arbiter.sv
`timescale 1ns/100ps
module sim_cur_sector_family_arbiter;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       period_stb = 1'b0;
   logic [2:0] phase_pos = 3'b000;
   logic [2:0] src_state = 3'b000;
   logic [2:0] dst_state = 3'b000;
   logic       fam_sel = 1'b0;
   logic [2:0] sector;
   logic       fam_ok;
   logic [2:0] dt_state;
   logic       dt_hazard;
   logic       sign_err;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   cur_sector_family_arbiter u0 (
      .clk(clk), .rst_n(rst_n), .period_stb(period_stb), .phase_pos(phase_pos),
      .src_state(src_state), .dst_state(dst_state), .fam_sel(fam_sel),
      .sector(sector), .fam_ok(fam_ok), .dt_state(dt_state),
      .dt_hazard(dt_hazard), .sign_err(sign_err));

   // signs, src, dst, exp sector, exp dt, exp hazard  (all a,b,c MSB first)
   typedef struct packed {
      logic [2:0] sg;
      logic [2:0] s;
      logic [2:0] d;
      logic [2:0] sec;
      logic [2:0] dt;
      logic       hz;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VT [NV] = '{
      '{3'b101, 3'b100, 3'b010, 3'd6, 3'b010, 1'b0},
      '{3'b110, 3'b100, 3'b010, 3'd2, 3'b000, 1'b1},
      '{3'b001, 3'b100, 3'b010, 3'd5, 3'b110, 1'b1},
      '{3'b011, 3'b110, 3'b011, 3'd4, 3'b110, 1'b0},
      '{3'b100, 3'b110, 3'b101, 3'd1, 3'b111, 1'b1},
      '{3'b010, 3'b011, 3'b101, 3'd3, 3'b101, 1'b0},
      '{3'b010, 3'b001, 3'b001, 3'd3, 3'b001, 1'b0},
      '{3'b100, 3'b100, 3'b110, 3'd1, 3'b110, 1'b1},
      '{3'b011, 3'b000, 3'b000, 3'd4, 3'b000, 1'b1},
      '{3'b101, 3'b001, 3'b100, 3'd6, 3'b000, 1'b1}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic strobe(input logic [2:0] sg);
      @(negedge clk);
      phase_pos  = sg;
      period_stb = 1'b1;
      @(negedge clk);
      period_stb = 1'b0;
   endtask

   task automatic check_fam(input logic [2:0] sec, input string req);
      fam_sel = 1'b0; #0.5;
      chk(fam_ok == (sec != 0 && !sec[0]), req, fam_ok, int'(sec != 0 && !sec[0]));
      fam_sel = 1'b1; #0.5;
      chk(fam_ok == (sec != 0 && sec[0]), req, fam_ok, int'(sec != 0 && sec[0]));
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R1 during reset
      repeat (3) @(negedge clk);
      chk(sector == 0, "R1", sector, 0);
      chk(sign_err == 0, "R1", sign_err, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sector == 0, "R1", sector, 0);
      check_fam(3'd0, "R1");

      // table walk: R2, R5, R6, R7, R8, R9
      for (int i = 0; i < NV; i++) begin
         strobe(VT[i].sg);
         chk(sector == VT[i].sec, "R2", sector, VT[i].sec);
         chk(sign_err == 0, "R2", sign_err, 0);
         check_fam(VT[i].sec, "R5");
         src_state = VT[i].s; dst_state = VT[i].d; #0.5;
         chk(dt_state == VT[i].dt, "R6", dt_state, VT[i].dt);
         chk(dt_hazard == VT[i].hz, "R9", dt_hazard, VT[i].hz);
         src_state = VT[i].d; dst_state = VT[i].s; #0.5;
         chk(dt_state == VT[i].dt, "R7", dt_state, VT[i].dt);
         chk(dt_hazard == VT[i].hz, "R7", dt_hazard, VT[i].hz);
      end

      // R3 / R10: signs move without a strobe; latched ones (101) stay in use
      strobe(3'b101);
      src_state = 3'b100; dst_state = 3'b010;
      @(negedge clk);
      phase_pos = 3'b110;
      repeat (3) @(negedge clk);
      chk(sector == 6, "R3", sector, 6);
      chk(dt_state == 3'b010, "R3", dt_state, 3'b010);
      chk(dt_hazard == 0, "R10", dt_hazard, 0);

      // R4: all-positive pattern holds sector and flags
      strobe(3'b111);
      chk(sector == 6, "R4", sector, 6);
      chk(sign_err == 1, "R4", sign_err, 1);
      // R10: latched 111 means both switching legs sit low -> 000, hazard (R8)
      chk(dt_state == 3'b000, "R10", dt_state, 0);
      chk(dt_hazard == 1, "R8", dt_hazard, 1);
      // all-negative pattern, legs a,b go high -> 110
      strobe(3'b000);
      chk(sector == 6, "R4", sector, 6);
      chk(sign_err == 1, "R4", sign_err, 1);
      chk(dt_state == 3'b110, "R10", dt_state, 3'b110);
      // valid strobe clears the flag
      strobe(3'b011);
      chk(sector == 4, "R4", sector, 4);
      chk(sign_err == 0, "R4", sign_err, 0);

      // R1: reset mid-run returns to the quiet state
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sector == 0, "R1", sector, 0);
      chk(sign_err == 0, "R1", sign_err, 0);
      check_fam(3'd0, "R1");

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule